// File: doc/BRIEF.md
# Load-Reserved / Store-Conditional Reservation Tracker

This block keeps the single reservation of one hart for the reserved-load / store-conditional pair and decides the outcome of each store-conditional. A load-reserved that completes without fault records the physical address of its target. The recorded address is kept as a tag at an 8-byte granule. A later store-conditional first checks its alignment and then its translation result. Its translated physical address is then compared against the held tag. From that comparison the block produces the store enable, the destination-register value and any exception code, all in the same cycle as the request.

The reservation is cleared by a store-conditional that reaches the address check, whether it succeeds or fails. It is also cleared by an explicit clear request, and by a snooped write from another agent that lands in the reserved granule. Nothing else clears it. A trap, a return from a trap and a wait-for-interrupt leave it in place, so this block has no input for those events. The block also decodes a 32-bit instruction word and reports whether it is a legal load-reserved or store-conditional.

Top module: `lrsc_resv_unit`

## Requirements
- R1: After reset there is no reservation: a store-conditional that is aligned and has no fault fails, so `sc_rd_we`=1, `sc_rd_data`=1 and `sc_store_en`=0.
- R2: A completed load-reserved (`lr_done`=1, `lr_fault`=0) sets the reservation on the granule `lr_paddr[PA_W-1:3]`. The reservation is held through any number of idle cycles. A later aligned store-conditional without fault whose `sc_paddr` lies in that granule succeeds in the same cycle: `sc_store_en`=1, `sc_rd_we`=1, `sc_rd_data`=0.
- R3: A load-reserved with `lr_fault`=1 leaves the reservation exactly as it was.
- R4: A store-conditional whose address low bits `sc_va_lo` are misaligned raises exception code 6. Misaligned means any of bits [1:0] set for a word (`sc_dbl`=0), or any of bits [2:0] set for a doubleword (`sc_dbl`=1). The store-conditional then gives no store and no register write, and the reservation is unchanged. Misalignment takes priority over any translation fault.
- R5: An aligned store-conditional with `sc_xlate_fault`=1 raises code 15 when `sc_xlate_pf`=1 and code 7 otherwise. It gives no store and no register write, and the reservation is unchanged.
- R6: An aligned store-conditional without fault that finds no reservation or a different granule writes 1 to rd with `sc_store_en`=0 and `sc_exc_valid`=0. It clears the reservation.
- R7: A successful store-conditional clears the reservation, so a second one to the same granule fails.
- R8: `snoop_valid` with `snoop_paddr` in the reserved granule clears the reservation. A snoop to any other granule leaves it intact.
- R9: `resv_clr`=1 clears the reservation.
- R10: A new completed load-reserved replaces any existing reservation with its own granule.
- R11: When a clear happens in the same cycle as a completed load-reserved, the clear wins and no reservation remains. A clear here means a store-conditional reaching the check, `resv_clr`, or a snoop hit.
- R12: Decode of `insn_word` gives `insn_legal`=1 only when all of these hold: `lrsc_en`=1, bits [6:0]=0101111, bits [14:12] equal 010 (or 011 when XLEN is 64), and either bits [31:27]=00010 with bits [24:20]=0 (load-reserved, `insn_is_lr`) or bits [31:27]=00011 (store-conditional, `insn_is_sc`). `insn_is_lr` and `insn_is_sc` are 0 whenever `insn_legal` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lrsc_en | input | 1 | Reserved-load/store-conditional extension enabled |
| insn_word | input | 32 | Instruction word to decode |
| insn_is_lr | output | 1 | Word is a legal load-reserved |
| insn_is_sc | output | 1 | Word is a legal store-conditional |
| insn_legal | output | 1 | Word is a legal instruction of this pair |
| lr_done | input | 1 | Load-reserved retiring this cycle |
| lr_fault | input | 1 | Its translation or read faulted |
| lr_paddr | input | PA_W | Its physical address |
| sc_req | input | 1 | Store-conditional committing this cycle |
| sc_va_lo | input | 3 | Low three bits of its virtual address |
| sc_dbl | input | 1 | 1 for doubleword, 0 for word |
| sc_xlate_fault | input | 1 | Write translation faulted |
| sc_xlate_pf | input | 1 | Fault is a page fault (else access fault) |
| sc_paddr | input | PA_W | Translated physical address |
| resv_clr | input | 1 | Explicit reservation clear |
| snoop_valid | input | 1 | Another agent writes this cycle |
| snoop_paddr | input | PA_W | Physical address of that write |
| sc_store_en | output | 1 | Perform the store |
| sc_rd_we | output | 1 | Write rd |
| sc_rd_data | output | XLEN | Value for rd: 0 success, 1 failure |
| sc_exc_valid | output | 1 | Store-conditional raises an exception |
| sc_exc_code | output | 5 | Exception cause code |

## Verification
The hardest cases to reach are same-cycle collisions, where a load-reserved arrives together with a clear, a snoop hit or a consuming store-conditional. Equally hard is showing that a faulting store-conditional leaves the reservation untouched, because the held state has no port of its own. The stimulus drives these events together in one cycle and then issues an aligned, fault-free store-conditional to the granule of interest as a probe. The probe's success or failure exposes whether the reservation survived. A sweep crosses alignment, width, fault kind, reservation presence and granule match, and follows every case with such a probe.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;
  localparam logic [6:0] OPC_ATOMIC  = 7'b0101111;
  localparam logic [4:0] F5_LOADRES  = 5'b00010;
  localparam logic [4:0] F5_STORECON = 5'b00011;
  localparam logic [2:0] F3_WORD     = 3'b010;
  localparam logic [2:0] F3_DWORD    = 3'b011;

  localparam logic [4:0] EXC_ST_MISALIGN = 5'd6;
  localparam logic [4:0] EXC_ST_ACCESS   = 5'd7;
  localparam logic [4:0] EXC_ST_PAGE     = 5'd15;

  typedef struct packed {
    logic       store_en;
    logic       rd_we;
    logic       rd_fail;
    logic       exc_valid;
    logic [4:0] exc_code;
    logic       consume;
  } sc_result_t;
endpackage

// File: rtl/lrsc_insn_decode.sv
module lrsc_insn_decode
  import lrsc_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [31:0] insn,
  input  logic        ext_en,
  output logic        is_lr,
  output logic        is_sc,
  output logic        legal
);
  logic [4:0] f5;
  logic [4:0] rs2;
  logic [2:0] f3;
  logic [6:0] opc;
  logic       width_ok;
  logic       lr_shape;
  logic       sc_shape;
  logic       unused_fields;

  assign f5  = insn[31:27];
  assign rs2 = insn[24:20];
  assign f3  = insn[14:12];
  assign opc = insn[6:0];
  assign unused_fields = ^{insn[26:25], insn[19:15], insn[11:7]};

  generate
    if (XLEN >= 64) begin : g_wide
      assign width_ok = (f3 == F3_WORD) || (f3 == F3_DWORD);
    end else begin : g_narrow
      assign width_ok = (f3 == F3_WORD);
    end
  endgenerate

  always_comb begin
    lr_shape = (f5 == F5_LOADRES) && (rs2 == 5'd0);
    sc_shape = (f5 == F5_STORECON);
    legal    = ext_en && (opc == OPC_ATOMIC) && width_ok && (lr_shape || sc_shape);
    is_lr    = legal && lr_shape;
    is_sc    = legal && sc_shape;
  end
endmodule

// File: rtl/lrsc_resv_store.sv
module lrsc_resv_store #(
  parameter int TAG_W = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [TAG_W-1:0] set_tag,
  input  logic             clr_en,
  output logic             q_valid,
  output logic [TAG_W-1:0] q_tag
);
  logic valid_d;
  logic tag_ld;

  always_comb begin
    valid_d = q_valid;
    tag_ld  = 1'b0;
    if (clr_en) begin
      valid_d = 1'b0;
    end else if (set_en) begin
      valid_d = 1'b1;
      tag_ld  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_valid <= 1'b0;
    else        q_valid <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (tag_ld) q_tag <= set_tag;
  end

  p_clear_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> !q_valid);

  p_set_records_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && !clr_en) |=> (q_valid && (q_tag == $past(set_tag))));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_en && !clr_en) |=> (q_valid == $past(q_valid)));
endmodule

// File: rtl/lrsc_sc_resolve.sv
module lrsc_sc_resolve
  import lrsc_pkg::*;
#(
  parameter int PA_W    = 34,
  parameter int GRAN_LG = 3
) (
  input  logic            req,
  input  logic [2:0]      va_lo,
  input  logic            dbl,
  input  logic            xl_fault,
  input  logic            xl_pf,
  input  logic [PA_W-1:0] paddr,
  input  logic            resv_valid,
  input  logic [PA_W-GRAN_LG-1:0] resv_tag,
  output sc_result_t      res
);
  localparam int TAG_W = PA_W - GRAN_LG;

  logic [2:0]       align_mask;
  logic             misaligned;
  logic             hit;
  logic [TAG_W-1:0] req_tag;
  logic             unused_lo;

  assign req_tag   = paddr[PA_W-1:GRAN_LG];
  assign unused_lo = ^paddr[GRAN_LG-1:0];

  always_comb begin
    align_mask = dbl ? 3'b111 : 3'b011;
    misaligned = |(va_lo & align_mask);
    hit        = resv_valid && (resv_tag == req_tag);

    res = '0;
    if (req) begin
      if (misaligned) begin
        res.exc_valid = 1'b1;
        res.exc_code  = EXC_ST_MISALIGN;
      end else if (xl_fault) begin
        res.exc_valid = 1'b1;
        res.exc_code  = xl_pf ? EXC_ST_PAGE : EXC_ST_ACCESS;
      end else begin
        res.consume  = 1'b1;
        res.rd_we    = 1'b1;
        res.store_en = hit;
        res.rd_fail  = !hit;
      end
    end
  end
endmodule

// File: rtl/lrsc_resv_unit.sv
module lrsc_resv_unit
  import lrsc_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter int PA_W    = 34,
  parameter int GRAN_LG = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lrsc_en,
  input  logic [31:0]     insn_word,
  output logic            insn_is_lr,
  output logic            insn_is_sc,
  output logic            insn_legal,
  input  logic            lr_done,
  input  logic            lr_fault,
  input  logic [PA_W-1:0] lr_paddr,
  input  logic            sc_req,
  input  logic [2:0]      sc_va_lo,
  input  logic            sc_dbl,
  input  logic            sc_xlate_fault,
  input  logic            sc_xlate_pf,
  input  logic [PA_W-1:0] sc_paddr,
  input  logic            resv_clr,
  input  logic            snoop_valid,
  input  logic [PA_W-1:0] snoop_paddr,
  output logic            sc_store_en,
  output logic            sc_rd_we,
  output logic [XLEN-1:0] sc_rd_data,
  output logic            sc_exc_valid,
  output logic [4:0]      sc_exc_code
);
  localparam int TAG_W = PA_W - GRAN_LG;

  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_sync;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  lrsc_insn_decode #(.XLEN(XLEN)) dec_i (
    .insn   (insn_word),
    .ext_en (lrsc_en),
    .is_lr  (insn_is_lr),
    .is_sc  (insn_is_sc),
    .legal  (insn_legal)
  );

  logic             resv_valid;
  logic [TAG_W-1:0] resv_tag;
  sc_result_t       sc_res;
  logic             snoop_hit;
  logic             clr_any;
  logic             set_any;
  logic             unused_addr;

  lrsc_sc_resolve #(.PA_W(PA_W), .GRAN_LG(GRAN_LG)) res_i (
    .req        (sc_req),
    .va_lo      (sc_va_lo),
    .dbl        (sc_dbl),
    .xl_fault   (sc_xlate_fault),
    .xl_pf      (sc_xlate_pf),
    .paddr      (sc_paddr),
    .resv_valid (resv_valid),
    .resv_tag   (resv_tag),
    .res        (sc_res)
  );

  assign unused_addr = ^{lr_paddr[GRAN_LG-1:0], snoop_paddr[GRAN_LG-1:0]};

  always_comb begin
    snoop_hit = snoop_valid && (snoop_paddr[PA_W-1:GRAN_LG] == resv_tag);
    clr_any   = sc_res.consume || resv_clr || snoop_hit;
    set_any   = lr_done && !lr_fault;
  end

  lrsc_resv_store #(.TAG_W(TAG_W)) store_i (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .set_en  (set_any),
    .set_tag (lr_paddr[PA_W-1:GRAN_LG]),
    .clr_en  (clr_any),
    .q_valid (resv_valid),
    .q_tag   (resv_tag)
  );

  assign sc_store_en  = sc_res.store_en;
  assign sc_rd_we     = sc_res.rd_we;
  assign sc_rd_data   = {{(XLEN-1){1'b0}}, sc_res.rd_fail};
  assign sc_exc_valid = sc_res.exc_valid;
  assign sc_exc_code  = sc_res.exc_code;

  p_exc_quiet_r5: assert property (@(posedge clk) disable iff (!rst_q_n)
    sc_exc_valid |-> (!sc_store_en && !sc_rd_we));

  p_exc_keeps_r4: assert property (@(posedge clk) disable iff (!rst_q_n)
    (sc_exc_valid && !lr_done && !resv_clr && !snoop_valid) |=> $stable(resv_valid));

  p_success_consumes_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
    sc_store_en |=> !resv_valid);

  p_fail_consumes_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (sc_rd_we && sc_rd_data[0]) |=> !resv_valid);

  p_snoop_clears_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    (snoop_valid && resv_valid && (snoop_paddr[PA_W-1:GRAN_LG] == resv_tag)) |=> !resv_valid);

  p_misalign_first_r4: assert property (@(posedge clk) disable iff (!rst_q_n)
    (sc_req && (sc_va_lo[1:0] != 2'b00)) |-> (sc_exc_valid && sc_exc_code == EXC_ST_MISALIGN));

  p_legal_needs_en_r12: assert property (@(posedge clk) disable iff (!rst_q_n)
    (insn_is_lr || insn_is_sc) |-> (insn_legal && lrsc_en && !(insn_is_lr && insn_is_sc)));

  p_clear_on_reset_r1: assert property (@(posedge clk)
    $rose(rst_q_n) |-> !resv_valid);
endmodule

// File: tb/lrsc_resv_unit_tb_top.sv
`timescale 1ns/1ps
module lrsc_resv_unit_tb_top;
  localparam int XLEN = 64;
  localparam int PA_W = 34;

  logic            clk;
  logic            rst_n;
  logic            lrsc_en;
  logic [31:0]     insn_word;
  logic            insn_is_lr, insn_is_sc, insn_legal;
  logic            lr_done, lr_fault;
  logic [PA_W-1:0] lr_paddr;
  logic            sc_req;
  logic [2:0]      sc_va_lo;
  logic            sc_dbl, sc_xlate_fault, sc_xlate_pf;
  logic [PA_W-1:0] sc_paddr;
  logic            resv_clr, snoop_valid;
  logic [PA_W-1:0] snoop_paddr;
  logic            sc_store_en, sc_rd_we, sc_exc_valid;
  logic [XLEN-1:0] sc_rd_data;
  logic [4:0]      sc_exc_code;

  int vecs = 0;
  int errs = 0;

  bit              exp_v = 1'b0;
  logic [PA_W-4:0] exp_tag = '0;

  lrsc_resv_unit #(.XLEN(XLEN), .PA_W(PA_W), .GRAN_LG(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .lrsc_en(lrsc_en), .insn_word(insn_word),
    .insn_is_lr(insn_is_lr), .insn_is_sc(insn_is_sc), .insn_legal(insn_legal),
    .lr_done(lr_done), .lr_fault(lr_fault), .lr_paddr(lr_paddr),
    .sc_req(sc_req), .sc_va_lo(sc_va_lo), .sc_dbl(sc_dbl),
    .sc_xlate_fault(sc_xlate_fault), .sc_xlate_pf(sc_xlate_pf), .sc_paddr(sc_paddr),
    .resv_clr(resv_clr), .snoop_valid(snoop_valid), .snoop_paddr(snoop_paddr),
    .sc_store_en(sc_store_en), .sc_rd_we(sc_rd_we), .sc_rd_data(sc_rd_data),
    .sc_exc_valid(sc_exc_valid), .sc_exc_code(sc_exc_code)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic idle();
    lr_done = 0; lr_fault = 0; lr_paddr = '0;
    sc_req = 0; sc_va_lo = 0; sc_dbl = 0; sc_xlate_fault = 0; sc_xlate_pf = 0; sc_paddr = '0;
    resv_clr = 0; snoop_valid = 0; snoop_paddr = '0;
  endtask

  // one cycle of stimulus; SC outputs checked mid-cycle, model updated at the edge
  task automatic apply(input bit lr, input logic [PA_W-1:0] lpa, input bit lf,
                       input bit sc, input logic [2:0] vlo, input bit dbl,
                       input bit xf, input bit xpf, input logic [PA_W-1:0] spa,
                       input bit clr, input bit snp, input logic [PA_W-1:0] npa,
                       input string req);
    bit mis, consume, clear;
    logic [8:0] exp_t, act_t;
    logic [XLEN-1:0] exp_rd;
    @(negedge clk);
    lr_done = lr; lr_paddr = lpa; lr_fault = lf;
    sc_req = sc; sc_va_lo = vlo; sc_dbl = dbl; sc_xlate_fault = xf; sc_xlate_pf = xpf;
    sc_paddr = spa; resv_clr = clr; snoop_valid = snp; snoop_paddr = npa;
    #1;
    mis = ((vlo & (dbl ? 3'b111 : 3'b011)) != 3'b000);
    exp_t = '0; exp_rd = '0; consume = 0;
    if (sc) begin
      if (mis) exp_t = {1'b0, 1'b0, 1'b0, 1'b1, 5'd6};
      else if (xf) exp_t = {1'b0, 1'b0, 1'b0, 1'b1, (xpf ? 5'd15 : 5'd7)};
      else begin
        consume = 1;
        if (exp_v && (spa[PA_W-1:3] == exp_tag)) exp_t = {1'b1, 1'b1, 1'b0, 1'b0, 5'd0};
        else begin exp_t = {1'b0, 1'b1, 1'b1, 1'b0, 5'd0}; exp_rd = 1; end
      end
    end
    act_t = {sc_store_en, sc_rd_we, sc_rd_data[0], sc_exc_valid, sc_exc_code};
    vecs++;
    if (act_t !== exp_t || sc_rd_data !== exp_rd) begin
      errs++;
      $display("FAIL %s: {st,we,rd,exc,code}=%h rd=%0h expected %h rd=%0h",
               req, act_t, sc_rd_data, exp_t, exp_rd);
    end
    clear = consume || clr || (snp && (npa[PA_W-1:3] == exp_tag));
    @(posedge clk);
    if (clear) exp_v = 0;
    else if (lr && !lf) begin exp_v = 1; exp_tag = lpa[PA_W-1:3]; end
    @(negedge clk);
    idle();
  endtask

  task automatic do_lr(input logic [PA_W-1:0] pa, input bit f, input string req);
    apply(1, pa, f, 0, 0, 0, 0, 0, '0, 0, 0, '0, req);
  endtask

  task automatic do_sc(input logic [2:0] vlo, input bit dbl, input bit xf, input bit xpf,
                       input logic [PA_W-1:0] pa, input string req);
    apply(0, '0, 0, 1, vlo, dbl, xf, xpf, pa, 0, 0, '0, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  localparam logic [PA_W-1:0] A = 34'h2_0000_1230;
  localparam logic [PA_W-1:0] B = 34'h1_8000_0040;

  initial begin
    logic [31:0] w;
    bit wok, lrs, scs, lg;
    logic [2:0] exp3, act3;
    idle();
    lrsc_en = 1; insn_word = '0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (3) @(posedge clk);

    // R1: nothing reserved after reset
    do_sc(3'd0, 1'b1, 0, 0, 34'h0, "R1 reset empty");
    do_sc(3'd0, 1'b0, 0, 0, A, "R1 reset empty A");

    // R2: set, persist, succeed at any low bits of the granule
    do_lr(A | 34'h7, 0, "R2 lr");
    repeat (20) @(posedge clk);
    do_sc(3'd4, 1'b0, 0, 0, A | 34'h4, "R2 match after idle");
    // R7: consumed
    do_sc(3'd0, 1'b0, 0, 0, A, "R7 second sc fails");

    // R3: faulting LR leaves reservation
    do_lr(A, 0, "R3 setup");
    do_lr(B, 1, "R3 faulted lr");
    do_sc(3'd0, 1'b1, 0, 0, A, "R3 original kept");
    do_lr(B, 1, "R3 faulted lr on empty");
    do_sc(3'd0, 1'b0, 0, 0, B, "R3 no reservation made");

    // R10: overwrite
    do_lr(A, 0, "R10 first");
    do_lr(B, 0, "R10 second");
    do_sc(3'd0, 1'b0, 0, 0, A, "R10 old granule fails");
    do_lr(A, 0, "R10 first again");
    do_lr(B, 0, "R10 second again");
    do_sc(3'd0, 1'b0, 0, 0, B, "R10 new granule succeeds");

    // R8: snoop in and out of the granule
    do_lr(A, 0, "R8 setup");
    apply(0, '0, 0, 0, 0, 0, 0, 0, '0, 0, 1, A | 34'h5, "R8 snoop same granule");
    do_sc(3'd0, 1'b0, 0, 0, A, "R8 cleared by snoop");
    do_lr(A, 0, "R8 setup 2");
    apply(0, '0, 0, 0, 0, 0, 0, 0, '0, 0, 1, A + 34'h8, "R8 snoop next granule");
    apply(0, '0, 0, 0, 0, 0, 0, 0, '0, 0, 1, A - 34'h1, "R8 snoop prev granule");
    do_sc(3'd0, 1'b0, 0, 0, A, "R8 survives other snoops");

    // R9: explicit clear
    do_lr(B, 0, "R9 setup");
    apply(0, '0, 0, 0, 0, 0, 0, 0, '0, 1, 0, '0, "R9 clear");
    do_sc(3'd0, 1'b0, 0, 0, B, "R9 cleared");

    // R11: clears beat a same-cycle LR
    apply(1, A, 0, 0, 0, 0, 0, 0, '0, 1, 0, '0, "R11 lr with clear");
    do_sc(3'd0, 1'b0, 0, 0, A, "R11 clear won");
    do_lr(B, 0, "R11 setup snoop");
    apply(1, A, 0, 0, 0, 0, 0, 0, '0, 0, 1, B, "R11 lr with snoop hit");
    do_sc(3'd0, 1'b0, 0, 0, A, "R11 snoop won");
    do_lr(B, 0, "R11 setup sc");
    apply(1, A, 0, 1, 3'd0, 0, 0, 0, B, 0, 0, '0, "R11 lr with consuming sc");
    do_sc(3'd0, 1'b0, 0, 0, A, "R11 sc won");

    // R4 R5 R6 R7: sweep over alignment, width, fault kind, presence and match
    for (int hv = 0; hv < 2; hv++)
      for (int same = 0; same < 2; same++)
        for (int dbl = 0; dbl < 2; dbl++)
          for (int lo = 0; lo < 8; lo++)
            for (int xf = 0; xf < 2; xf++)
              for (int xpf = 0; xpf < 2; xpf++) begin
                if (hv != 0) do_lr(A, 0, "R2 sweep lr");
                do_sc(3'(lo), dbl[0], xf[0], xpf[0],
                      (same != 0 ? A : A + 34'h40) | 34'(lo),
                      "R4 R5 R6 sweep sc");
                do_sc(3'd0, 1'b0, 0, 0, A, "R4 R5 R7 sweep probe");
              end

    // R12: decode sweep
    for (int en = 0; en < 2; en++)
      for (int op = 0; op < 2; op++)
        for (int f5 = 0; f5 < 32; f5++)
          for (int f3 = 0; f3 < 8; f3++)
            for (int r2 = 0; r2 < 2; r2++) begin
              w = {f5[4:0], f5[0], f5[1], (r2 != 0 ? 5'd7 : 5'd0), 5'(f5 + 3),
                   f3[2:0], 5'(f3 * 3), (op != 0 ? 7'h2F : 7'h03)};
              lrsc_en = en[0]; insn_word = w;
              #1;
              wok = (f3 == 2) || (f3 == 3);
              lrs = (f5 == 2) && (r2 == 0);
              scs = (f5 == 3);
              lg  = (en != 0) && (op != 0) && wok && (lrs || scs);
              exp3 = {lg, lg && lrs, lg && scs};
              act3 = {insn_legal, insn_is_lr, insn_is_sc};
              vecs++;
              if (act3 !== exp3) begin
                errs++;
                $display("FAIL R12 decode word=%h en=%0d: {legal,lr,sc}=%b expected %b",
                         w, en, act3, exp3);
              end
            end

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule